// File: doc/BRIEF.md
# Hierarchical Transfer Sequencer

This block paces a data mover through a three-level hierarchy. Beats form fragments, fragments form blocks, and blocks form one transaction. Software programs the fragment length, the number of fragments in a block and the number of blocks in a transaction. Software also chooses a request mode, which sets how much work one hardware request strobe permits. The block then raises a beat enable, and the mover answers it with a beat-accepted strobe for every beat it moves. Addresses and the bus protocol belong to the mover, not to this block.

The block emits one-cycle done pulses for each level of the hierarchy. It also keeps a set of sticky status bits and drives one interrupt line. The programmed interrupt type selects which status bits reach that line. A request that arrives while a unit is still running is held in a single queue slot. A request that finds the slot already full is dropped and flagged. A request made while the configuration is invalid is refused and flagged as a configuration error.

Top module: `xfer_seq`

## Requirements
- R1: After reset, beatEn, every done pulse, intStatus and intLine are all low.
- R2: A request with a valid configuration raises beatEn in the next cycle. The unit then lasts exactly fragLen beats in request mode 0, fragLen*fragsPerBlk beats in mode 1, and fragLen*fragsPerBlk*blksPerTrans beats in modes 2 and 3. After that, beatEn falls if no request is queued.
- R3: In request mode 0 or 1, position is kept across requests. Enough requests to cover one transaction produce exactly one transaction completion.
- R4: fragDone, blkDone and transDone are one-cycle pulses. They rise in the cycle after the final beat of their unit is accepted. A fragment that ends a block, or a block that ends a transaction, raises both levels in the same cycle.
- R5: In request mode 3, listDone pulses together with transDone. In the other modes listDone stays low.
- R6: The intStatus bits are sticky: bit0 fragment, bit1 block, bit2 transaction, bit3 list, bit4 configuration error, bit5 request overflow. Writing 1 to a bit of intClr clears that bit. A new event in the same cycle wins over the clear.
- R7: intLine is the OR of the status bits that the interrupt type enables. The encoding is: 0 none, 1 fragment, 2 block, 3 block or fragment, 4 transaction, 5 transaction or fragment, 6 transaction or block, 7 list, 8 configuration error.
- R8: A configuration is invalid when any count is zero or when the interrupt type is above 8. A request made while the configuration is invalid sets status bit4 and starts no work.
- R9: A request that arrives while a unit runs is queued, with a depth of one. The queued unit follows immediately, and beatEn stays high between the two units.
- R10: A request that arrives while the queue slot is full sets status bit5 and adds no work.
- R11: beatAccept has no effect while beatEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgFragLen | input | LEN_W | Beats per fragment |
| cfgFragsPerBlk | input | CNT_W | Fragments per block |
| cfgBlksPerTrans | input | CNT_W | Blocks per transaction |
| cfgReqMode | input | 2 | Work per request: 0 fragment, 1 block, 2 transaction, 3 list |
| cfgIntType | input | 4 | Interrupt type selecting enabled status bits |
| reqStrobe | input | 1 | Hardware request, one cycle |
| beatAccept | input | 1 | Mover accepted the current beat |
| intClr | input | 6 | Write-one-to-clear for intStatus |
| beatEn | output | 1 | Beats may move |
| fragDone | output | 1 | Fragment completed pulse |
| blkDone | output | 1 | Block completed pulse |
| transDone | output | 1 | Transaction completed pulse |
| listDone | output | 1 | List completed pulse (mode 3) |
| intStatus | output | 6 | Sticky event bits |
| intLine | output | 1 | Interrupt request |

## Verification
beatEn rises one cycle after the edge that takes a request. The done pulses and their status bits appear one cycle after the edge that accepts the final beat. intLine follows status combinationally, so it is due in the same cycle as status. The bench drives inputs and samples outputs at falling edges. It records the done pulses in the iteration where beatEn is first seen low, so each pulse is read exactly once, in the cycle in which it is due. The bench sweeps small configurations across every request mode and every interrupt type, and it computes the expected beat counts and pulse counts by arithmetic.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
  localparam int STAT_W   = 6;
  localparam int ST_FRAG  = 0;
  localparam int ST_BLK   = 1;
  localparam int ST_TRANS = 2;
  localparam int ST_LIST  = 3;
  localparam int ST_CFG   = 4;
  localparam int ST_OVF   = 5;
  localparam int INT_TYPE_MAX = 8;

  typedef enum logic [1:0] {
    REQ_FRAG  = 2'd0,
    REQ_BLK   = 2'd1,
    REQ_TRANS = 2'd2,
    REQ_LIST  = 2'd3
  } req_mode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic step;
    logic listMode;
  } seq_cmd_t;

  // datapath -> control completion flags (same cycle as accepted beat)
  typedef struct packed {
    logic frag;
    logic blk;
    logic trans;
  } seq_end_t;

  function automatic logic [ST_CFG:0] typeMask(input logic [3:0] t);
    logic [ST_CFG:0] m;
    m = '0;
    if (t >= 4'd1 && t <= 4'd6) m[ST_TRANS:ST_FRAG] = t[2:0];
    if (t == 4'd7) m[ST_LIST] = 1'b1;
    if (t == 4'd8) m[ST_CFG] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/xfer_seq_dp.sv
module xfer_seq_dp
  import xfer_seq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] cfgFragLen,
  input  logic [CNT_W-1:0] cfgFragsPerBlk,
  input  logic [CNT_W-1:0] cfgBlksPerTrans,
  input  seq_cmd_t         cmd,
  output seq_end_t         ends,
  output logic             fragDone,
  output logic             blkDone,
  output logic             transDone,
  output logic             listDone
);
  logic [LEN_W-1:0] beatCnt;
  logic [CNT_W-1:0] fragCnt;
  logic [CNT_W-1:0] blkCnt;

  always_comb begin
    ends.frag  = cmd.step && (beatCnt == cfgFragLen - LEN_W'(1));
    ends.blk   = ends.frag && (fragCnt == cfgFragsPerBlk - CNT_W'(1));
    ends.trans = ends.blk && (blkCnt == cfgBlksPerTrans - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt <= '0;
      fragCnt <= '0;
      blkCnt  <= '0;
    end else if (cmd.step) begin
      beatCnt <= ends.frag ? '0 : beatCnt + LEN_W'(1);
      if (ends.blk)       fragCnt <= '0;
      else if (ends.frag) fragCnt <= fragCnt + CNT_W'(1);
      if (ends.trans)     blkCnt <= '0;
      else if (ends.blk)  blkCnt <= blkCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fragDone  <= 1'b0;
      blkDone   <= 1'b0;
      transDone <= 1'b0;
      listDone  <= 1'b0;
    end else begin
      fragDone  <= ends.frag;
      blkDone   <= ends.blk;
      transDone <= ends.trans;
      listDone  <= ends.trans && cmd.listMode;
    end
  end

  // R4: completion pulses nest
  a_r4_blk_nests: assert property (@(posedge clk) disable iff (!rstN)
    blkDone |-> fragDone);
  a_r4_trans_nests: assert property (@(posedge clk) disable iff (!rstN)
    transDone |-> blkDone);
  // R5: list completion only alongside transaction completion
  a_r5_list_with_trans: assert property (@(posedge clk) disable iff (!rstN)
    listDone |-> transDone);
  // R11: counters hold without an accepted beat
  a_r11_hold_position: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.step |=> $stable(beatCnt) && $stable(fragCnt) && $stable(blkCnt));
endmodule

// File: rtl/xfer_seq_ctrl.sv
module xfer_seq_ctrl
  import xfer_seq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEN_W-1:0]  cfgFragLen,
  input  logic [CNT_W-1:0]  cfgFragsPerBlk,
  input  logic [CNT_W-1:0]  cfgBlksPerTrans,
  input  logic [1:0]        cfgReqMode,
  input  logic [3:0]        cfgIntType,
  input  logic              reqStrobe,
  input  logic              beatAccept,
  input  logic [STAT_W-1:0] intClr,
  input  seq_end_t          ends,
  output seq_cmd_t          cmd,
  output logic              beatEn,
  output logic [STAT_W-1:0] intStatus,
  output logic              intLine
);
  logic active, pending;
  logic cfgValid, reqOk, reqBad, unitEnd;
  logic [STAT_W-1:0] statSet;
  req_mode_e mode;

  assign mode = req_mode_e'(cfgReqMode);

  always_comb begin
    cfgValid = (cfgFragLen != '0) && (cfgFragsPerBlk != '0) &&
               (cfgBlksPerTrans != '0) && (cfgIntType <= 4'(INT_TYPE_MAX));
    reqOk  = reqStrobe && cfgValid;
    reqBad = reqStrobe && !cfgValid;
    cmd.step     = active && beatAccept;
    cmd.listMode = (mode == REQ_LIST);
    case (mode)
      REQ_FRAG: unitEnd = ends.frag;
      REQ_BLK:  unitEnd = ends.blk;
      default:  unitEnd = ends.trans;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      pending <= 1'b0;
    end else if (!active) begin
      active  <= reqOk;
      pending <= 1'b0;
    end else if (unitEnd) begin
      active  <= pending || reqOk;
      pending <= pending && reqOk;
    end else begin
      pending <= pending || reqOk;
    end
  end

  always_comb begin
    statSet           = '0;
    statSet[ST_FRAG]  = ends.frag;
    statSet[ST_BLK]   = ends.blk;
    statSet[ST_TRANS] = ends.trans;
    statSet[ST_LIST]  = ends.trans && cmd.listMode;
    statSet[ST_CFG]   = reqBad;
    statSet[ST_OVF]   = active && !unitEnd && pending && reqOk;
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rstN)           intStatus[b] <= 1'b0;
      else if (statSet[b]) intStatus[b] <= 1'b1;
      else if (intClr[b])  intStatus[b] <= 1'b0;
    end
  end

  assign beatEn  = active;
  assign intLine = |(intStatus[ST_CFG:0] & typeMask(cfgIntType));

  // R9: the queue slot is only occupied behind a running unit
  a_r9_pending_needs_active: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> active);
  // R8: a bad request is flagged and starts nothing
  a_r8_bad_flagged: assert property (@(posedge clk) disable iff (!rstN)
    reqBad |=> intStatus[ST_CFG]);
  a_r8_bad_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (!active && reqBad) |=> !beatEn);
  // R10: overflow only from a request meeting a full slot
  a_r10_ovf_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus[ST_OVF]) |-> $past(pending && reqStrobe));
  // R7: type 0 never interrupts
  a_r7_none_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIntType == 4'd0) |-> !intLine);
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_seq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEN_W-1:0]  cfgFragLen,
  input  logic [CNT_W-1:0]  cfgFragsPerBlk,
  input  logic [CNT_W-1:0]  cfgBlksPerTrans,
  input  logic [1:0]        cfgReqMode,
  input  logic [3:0]        cfgIntType,
  input  logic              reqStrobe,
  input  logic              beatAccept,
  input  logic [STAT_W-1:0] intClr,
  output logic              beatEn,
  output logic              fragDone,
  output logic              blkDone,
  output logic              transDone,
  output logic              listDone,
  output logic [STAT_W-1:0] intStatus,
  output logic              intLine
);
  seq_cmd_t cmd;
  seq_end_t ends;

  xfer_seq_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgFragLen(cfgFragLen), .cfgFragsPerBlk(cfgFragsPerBlk),
    .cfgBlksPerTrans(cfgBlksPerTrans), .cfgReqMode(cfgReqMode),
    .cfgIntType(cfgIntType), .reqStrobe(reqStrobe), .beatAccept(beatAccept),
    .intClr(intClr), .ends(ends), .cmd(cmd), .beatEn(beatEn),
    .intStatus(intStatus), .intLine(intLine)
  );

  xfer_seq_dp #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgFragLen(cfgFragLen), .cfgFragsPerBlk(cfgFragsPerBlk),
    .cfgBlksPerTrans(cfgBlksPerTrans), .cmd(cmd), .ends(ends),
    .fragDone(fragDone), .blkDone(blkDone), .transDone(transDone),
    .listDone(listDone)
  );
endmodule

// File: tb/xfer_seq_bench.sv
module xfer_seq_bench;
  localparam int LEN_W = 8;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LEN_W-1:0] cfgFragLen = '0;
  logic [CNT_W-1:0] cfgFragsPerBlk = '0;
  logic [CNT_W-1:0] cfgBlksPerTrans = '0;
  logic [1:0] cfgReqMode = '0;
  logic [3:0] cfgIntType = '0;
  logic reqStrobe = 1'b0;
  logic beatAccept = 1'b0;
  logic [5:0] intClr = '0;
  logic beatEn, fragDone, blkDone, transDone, listDone, intLine;
  logic [5:0] intStatus;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  xfer_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_xfer_seq (
    .clk(clk), .rstN(rstN), .cfgFragLen(cfgFragLen),
    .cfgFragsPerBlk(cfgFragsPerBlk), .cfgBlksPerTrans(cfgBlksPerTrans),
    .cfgReqMode(cfgReqMode), .cfgIntType(cfgIntType), .reqStrobe(reqStrobe),
    .beatAccept(beatAccept), .intClr(intClr), .beatEn(beatEn),
    .fragDone(fragDone), .blkDone(blkDone), .transDone(transDone),
    .listDone(listDone), .intStatus(intStatus), .intLine(intLine)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int maskOf(input int t);
    if (t >= 1 && t <= 6) return t;
    if (t == 7) return 8;
    if (t == 8) return 16;
    return 0;
  endfunction

  task automatic clearAll();
    @(negedge clk) intClr = 6'h3F;
    @(negedge clk) intClr = 6'h00;
  endtask

  task automatic runUnit(input bit gappy, output int beats, output int fd,
                         output int bd, output int td, output int ld);
    beats = 0; fd = 0; bd = 0; td = 0; ld = 0;
    @(negedge clk) reqStrobe = 1'b1;
    @(negedge clk) reqStrobe = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      fd += int'(fragDone); bd += int'(blkDone);
      td += int'(transDone); ld += int'(listDone);
      if (!beatEn) break;
      beatAccept = gappy ? (i % 3 != 1) : 1'b1;
      if (beatAccept) beats++;
      @(negedge clk);
    end
    beatAccept = 1'b0;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int beats, fd, bd, td, ld, unit, nReq, sfd, sbd, std, sld, expStat, expInt;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(beatEn == 0 && fragDone == 0 && blkDone == 0 && transDone == 0 &&
          listDone == 0, "R1 outputs", int'(beatEn), 0);
    check(intStatus == 0 && intLine == 0, "R1 status", int'(intStatus), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R11: beatAccept while idle has no effect
    cfgFragLen = 2; cfgFragsPerBlk = 1; cfgBlksPerTrans = 1; cfgReqMode = 0; cfgIntType = 1;
    beatAccept = 1'b1;
    repeat (4) @(negedge clk);
    beatAccept = 1'b0;
    check(beatEn == 0 && intStatus == 0, "R11 idle accept", int'(intStatus), 0);
    runUnit(1'b0, beats, fd, bd, td, ld);
    check(beats == 2 && fd == 1, "R11 position untouched", beats, 2);
    clearAll();

    // R8: invalid configurations refused
    for (int k = 0; k < 4; k++) begin
      cfgFragLen = (k == 0) ? 0 : 2;
      cfgFragsPerBlk = (k == 1) ? 0 : 1;
      cfgBlksPerTrans = (k == 2) ? 0 : 1;
      cfgIntType = (k == 3) ? 4'd9 : 4'd8;
      @(negedge clk) reqStrobe = 1'b1;
      @(negedge clk) reqStrobe = 1'b0;
      check(beatEn == 0, "R8 no start", int'(beatEn), 0);
      check(intStatus == 6'h10, "R8 cfg error bit", int'(intStatus), 16);
      if (k < 3) check(intLine == 1, "R7 cfg error interrupt", int'(intLine), 1);
      clearAll();
    end

    // R9 / R10: queue depth one and overflow
    cfgFragLen = 3; cfgFragsPerBlk = 2; cfgBlksPerTrans = 1; cfgReqMode = 0; cfgIntType = 0;
    beats = 0; fd = 0;
    @(negedge clk) reqStrobe = 1'b1;
    @(negedge clk) reqStrobe = 1'b0;
    for (int i = 0; i < 100; i++) begin
      fd += int'(fragDone);
      if (!beatEn) break;
      reqStrobe = (i < 2);
      beatAccept = 1'b1;
      beats++;
      @(negedge clk);
    end
    reqStrobe = 1'b0; beatAccept = 1'b0;
    check(beats == 6, "R9 queued unit back to back", beats, 6);
    check(fd == 2, "R9 two fragments", fd, 2);
    check(intStatus[5] == 1, "R10 overflow flagged", int'(intStatus[5]), 1);
    check(intLine == 0, "R7 type none", int'(intLine), 0);
    // R6: partial clear leaves other bits
    @(negedge clk) intClr = 6'h01;
    @(negedge clk) intClr = 6'h00;
    check(intStatus == 6'h26, "R6 partial clear", int'(intStatus), 'h26);
    clearAll();

    // Sweep: sizes x request mode x interrupt type
    for (int len = 1; len <= 3; len++)
      for (int fpb = 1; fpb <= 2; fpb++)
        for (int bpt = 1; bpt <= 2; bpt++)
          for (int m = 0; m < 4; m++)
            for (int t = 0; t <= 8; t++) begin
              cfgFragLen = LEN_W'(len); cfgFragsPerBlk = CNT_W'(fpb);
              cfgBlksPerTrans = CNT_W'(bpt); cfgReqMode = 2'(m); cfgIntType = 4'(t);
              unit = (m == 0) ? len : (m == 1) ? len * fpb : len * fpb * bpt;
              nReq = (len * fpb * bpt) / unit;
              sfd = 0; sbd = 0; std = 0; sld = 0;
              for (int r = 0; r < nReq; r++) begin
                runUnit(((len + m + t) % 2) == 1, beats, fd, bd, td, ld);
                check(beats == unit, "R2 beats per request", beats, unit);
                sfd += fd; sbd += bd; std += td; sld += ld;
              end
              check(sfd == fpb * bpt, "R4 fragment pulses", sfd, fpb * bpt);
              check(sbd == bpt, "R3 block pulses across requests", sbd, bpt);
              check(std == 1, "R3 one transaction", std, 1);
              check(sld == ((m == 3) ? 1 : 0), "R5 list pulse", sld, (m == 3) ? 1 : 0);
              expStat = 7 + ((m == 3) ? 8 : 0);
              check(int'(intStatus) == expStat, "R6 sticky status", int'(intStatus), expStat);
              expInt = ((expStat & maskOf(t)) != 0) ? 1 : 0;
              check(int'(intLine) == expInt, "R7 interrupt select", int'(intLine), expInt);
              clearAll();
              check(intStatus == 0, "R6 clear all", int'(intStatus), 0);
            end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule